// File: doc/BRIEF.md
# Pausable Chunk Read-Out Streamer

This block moves completed 4 KB read chunks out of a slotted read buffer and onto a 256-bit user stream. The buffer is arranged as `SLOTS` slots of 128 beats each. Slots are filled by separate logic, always in command order. That logic raises `fill_done_i` for one cycle when the last beat of the next slot has landed. The streamer keeps a count of chunks that are fully present and not yet read. It walks a read pointer through slot and beat indices and sends one buffer read request per cycle. It presents each returned beat with `out_valid_o` and the slot number as the chunk ID.

The stream has no ready signal. The consumer must take every beat presented while `out_valid_o` is high. To slow the stream, the consumer raises `pause_i`. A short register pipeline turns the pause into a stop of the read requests. The output therefore stops and restarts within a small, fixed number of cycles, and no beat is lost or repeated. One cycle after the last beat of a chunk, `retire_o` pulses so that the command queue can pop the matching entry and reuse the slot.

Top module: `chunk_stream_out`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid_o`, `retire_o` and `buf_rd_en_o` are 0 and `out_id_o` is 0.
- R2: No buffer read is requested and no beat is presented unless a fill pulse has been received for a chunk not yet fully read. With `pause_i` low, the first beat of a chunk whose fill pulse is sampled at a clock edge is presented in the third cycle after that edge.
- R3: A chunk is exactly 128 beats. With `pause_i` low and further chunks already filled, `out_valid_o` stays high without a gap for 128 cycles per chunk, across chunk boundaries.
- R4: Take the cycle in which `pause_i` first goes high as cycle 0. From the third cycle after it onward, `out_valid_o` is low for as long as `pause_i` stays high, so at most two more beats are presented after cycle 0.
- R5: Take the cycle in which `pause_i` returns low as cycle 0. If beats of a filled chunk remain, `out_valid_o` is high again in the third cycle after it, which is within four cycles.
- R6: Chunks come out in ascending slot order, each as beats 0 to 127 in order. Every beat carries the buffer data read for that slot and beat, unchanged. No beat is dropped or repeated, whatever the pause pattern.
- R7: `out_id_o` equals the slot number of the beat being presented. It stays constant within a chunk, steps by one per chunk, and wraps from `SLOTS-1` to 0.
- R8: `retire_o` is high for exactly one cycle, the cycle directly after the cycle that presents beat 127 of a chunk, and at no other time.
- R9: Each buffer read request drives `buf_rd_en_o` high with the slot and beat index on `buf_rd_slot_o` and `buf_rd_beat_o`. The buffer returns the data on `buf_rd_data_i` in the following cycle. The first request after reset is for slot 0, beat 0.
- R10: Fill pulses that arrive while the stream is paused or busy are all queued. Every filled chunk is presented exactly once, so the number of retire pulses ends up equal to the number of fill pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_done_i | input | 1 | One-cycle pulse: the next slot in order now holds a complete chunk |
| pause_i | input | 1 | Consumer asks the stream to halt |
| buf_rd_en_o | output | 1 | Buffer read request |
| buf_rd_slot_o | output | $clog2(SLOTS) | Slot index of the read request |
| buf_rd_beat_o | output | 7 | Beat index within the slot of the read request |
| buf_rd_data_i | input | 256 | Buffer read data, valid the cycle after the request |
| out_valid_o | output | 1 | Beat presented on the output stream |
| out_data_o | output | 256 | Beat data |
| out_id_o | output | $clog2(SLOTS) | Chunk ID (slot number) of the presented beat |
| retire_o | output | 1 | One-cycle pulse after the last beat of a chunk |

## Verification
The hardest situations to create are those in which a pause lands while read requests are still in flight, and in which a fill pulse arrives during a long pause. These are the cases where a beat could be lost or sent twice. The stimulus first fills two chunks, raises pause deep inside the first chunk and holds it for many cycles while a third fill pulse arrives. It then releases pause and follows with a train of one-cycle pause pulses every few beats, so that stops fall on arbitrary beat indices. A scoreboard follows slot and beat order for every presented beat. A final burst of thirty chunks forces the ID to wrap.

// File: rtl/chunk_stream_pkg.sv
package chunk_stream_pkg;

    // Width of one stream beat and number of beats that make up a 4 KB chunk.
    localparam int unsigned BEAT_W      = 256;
    localparam int unsigned CHUNK_BEATS = 128;
    localparam int unsigned BEAT_IDX_W  = $clog2(CHUNK_BEATS);

    typedef logic [BEAT_IDX_W-1:0] beat_idx_t;
    typedef logic [BEAT_W-1:0]     beat_data_t;

    localparam beat_idx_t BEAT_TOP = beat_idx_t'(CHUNK_BEATS - 1);

    // Tag that travels alongside each outstanding buffer read.
    typedef struct packed {
        logic valid;
        logic last;
    } rd_tag_t;

    localparam rd_tag_t TAG_IDLE = '{valid: 1'b0, last: 1'b0};

endpackage

// File: rtl/chunk_stream_pause_pipe.sv
// Registers the consumer's pause request before it gates read issue.
module chunk_stream_pause_pipe #(
    parameter int unsigned STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic pause_i,
    output logic hold_o
);

    generate
        if (STAGES == 0) begin : g_direct
            assign hold_o = pause_i;
        end else begin : g_reg
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else begin
                    sr[0] <= pause_i;
                    for (int i = 1; i < STAGES; i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end
            assign hold_o = sr[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/chunk_stream_tracker.sv
// Counts chunks that are completely filled but whose beats are not all issued.
module chunk_stream_tracker #(
    parameter int unsigned SLOTS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic fill_i,
    input  logic take_i,
    output logic any_o
);

    localparam int unsigned CNT_W = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] ready_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_cnt <= '0;
        end else begin
            unique case ({fill_i, take_i})
                2'b10:   ready_cnt <= ready_cnt + CNT_W'(1);
                2'b01:   ready_cnt <= ready_cnt - CNT_W'(1);
                default: ready_cnt <= ready_cnt;
            endcase
        end
    end

    assign any_o = (ready_cnt != '0);

endmodule

// File: rtl/chunk_stream_rd_ptr.sv
// Slot/beat read pointer; beat wraps per chunk, slot wraps at SLOTS.
module chunk_stream_rd_ptr
    import chunk_stream_pkg::*;
#(
    parameter  int unsigned SLOTS = 32,
    localparam int unsigned ID_W  = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_i,
    output logic [ID_W-1:0] slot_o,
    output beat_idx_t       beat_o,
    output logic            last_o
);

    localparam logic [ID_W-1:0] SLOT_TOP = ID_W'(SLOTS - 1);

    assign last_o = (beat_o == BEAT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_o <= '0;
            beat_o <= '0;
        end else if (step_i) begin
            if (last_o) begin
                beat_o <= '0;
                slot_o <= (slot_o == SLOT_TOP) ? '0 : slot_o + ID_W'(1);
            end else begin
                beat_o <= beat_o + beat_idx_t'(1);
            end
        end
    end

endmodule

// File: rtl/chunk_stream_out.sv
// Streams filled chunks from the slotted buffer with pause-based flow control.
module chunk_stream_out
    import chunk_stream_pkg::*;
#(
    parameter  int unsigned SLOTS        = 32,
    parameter  int unsigned PAUSE_STAGES = 1,
    localparam int unsigned ID_W         = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fill_done_i,
    input  logic                  pause_i,
    output logic                  buf_rd_en_o,
    output logic [ID_W-1:0]       buf_rd_slot_o,
    output logic [BEAT_IDX_W-1:0] buf_rd_beat_o,
    input  logic [BEAT_W-1:0]     buf_rd_data_i,
    output logic                  out_valid_o,
    output logic [BEAT_W-1:0]     out_data_o,
    output logic [ID_W-1:0]       out_id_o,
    output logic                  retire_o
);

    logic            hold;
    logic            chunk_ready;
    logic            issue;
    logic            issue_last;
    logic [ID_W-1:0] ptr_slot;
    beat_idx_t       ptr_beat;

    rd_tag_t         rd_tag;
    logic [ID_W-1:0] rd_slot;
    rd_tag_t         out_tag;

    chunk_stream_pause_pipe #(
        .STAGES (PAUSE_STAGES)
    ) u_pause (
        .clk     (clk),
        .rst     (rst),
        .pause_i (pause_i),
        .hold_o  (hold)
    );

    chunk_stream_tracker #(
        .SLOTS (SLOTS)
    ) u_track (
        .clk    (clk),
        .rst    (rst),
        .fill_i (fill_done_i),
        .take_i (issue && issue_last),
        .any_o  (chunk_ready)
    );

    chunk_stream_rd_ptr #(
        .SLOTS (SLOTS)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .step_i (issue),
        .slot_o (ptr_slot),
        .beat_o (ptr_beat),
        .last_o (issue_last)
    );

    // One read per cycle while a filled chunk has beats left and no hold.
    assign issue         = chunk_ready && !hold;
    assign buf_rd_en_o   = issue;
    assign buf_rd_slot_o = ptr_slot;
    assign buf_rd_beat_o = ptr_beat;

    // Stage 1: read in flight, buffer answers next cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_tag  <= TAG_IDLE;
            rd_slot <= '0;
        end else begin
            rd_tag  <= '{valid: issue, last: issue && issue_last};
            if (issue) begin
                rd_slot <= ptr_slot;
            end
        end
    end

    // Stage 2: output register; retire follows the last beat by one cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_tag    <= TAG_IDLE;
            out_data_o <= '0;
            out_id_o   <= '0;
            retire_o   <= 1'b0;
        end else begin
            out_tag  <= rd_tag;
            retire_o <= out_tag.valid && out_tag.last;
            if (rd_tag.valid) begin
                out_data_o <= buf_rd_data_i;
                out_id_o   <= rd_slot;
            end
        end
    end

    assign out_valid_o = out_tag.valid;

endmodule

// File: rtl/chunk_stream_out_chk.sv
module chunk_stream_out_chk
    import chunk_stream_pkg::*;
#(
    parameter  int unsigned SLOTS        = 32,
    parameter  int unsigned PAUSE_STAGES = 1,
    localparam int unsigned ID_W         = $clog2(SLOTS)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  fill_done_i,
    input logic                  pause_i,
    input logic                  buf_rd_en_o,
    input logic [ID_W-1:0]       buf_rd_slot_o,
    input logic [BEAT_IDX_W-1:0] buf_rd_beat_o,
    input logic [BEAT_W-1:0]     buf_rd_data_i,
    input logic                  out_valid_o,
    input logic [BEAT_W-1:0]     out_data_o,
    input logic [ID_W-1:0]       out_id_o,
    input logic                  retire_o
);

    localparam int unsigned LAT = PAUSE_STAGES + 2;
    localparam logic [ID_W-1:0] ID_TOP = ID_W'(SLOTS - 1);

    logic [15:0]     pend_cnt;
    logic [ID_W-1:0] exp_slot;
    beat_idx_t       exp_beat;
    logic [2:0]      pause_run;
    logic [8:0]      beat_run;
    logic            rd_last;

    assign rd_last = buf_rd_en_o && (buf_rd_beat_o == BEAT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cnt  <= '0;
            exp_slot  <= '0;
            exp_beat  <= '0;
            pause_run <= '0;
            beat_run  <= '0;
        end else begin
            pend_cnt <= pend_cnt + 16'(fill_done_i) - 16'(rd_last);
            if (buf_rd_en_o) begin
                exp_beat <= exp_beat + beat_idx_t'(1);
                if (exp_beat == BEAT_TOP) begin
                    exp_slot <= (exp_slot == ID_TOP) ? '0 : exp_slot + ID_W'(1);
                end
            end
            if (!pause_i) begin
                pause_run <= '0;
            end else if (pause_run < 3'(LAT)) begin
                pause_run <= pause_run + 3'd1;
            end
            if (retire_o) begin
                beat_run <= 9'(out_valid_o);
            end else if (out_valid_o) begin
                beat_run <= beat_run + 9'd1;
            end
        end
    end

    AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        buf_rd_en_o |-> pend_cnt != '0); // R2
    AST_CHUNK_LEN: assert property (@(posedge clk) disable iff (rst)
        retire_o |-> beat_run == 9'(CHUNK_BEATS)); // R3
    AST_PAUSE_STOP: assert property (@(posedge clk) disable iff (rst)
        pause_run >= 3'(LAT) |-> !out_valid_o); // R4
    AST_RESUME: assert property (@(posedge clk) disable iff (rst)
        !$past(pause_i, LAT) && $past(pend_cnt != '0, 2) |-> out_valid_o); // R5
    AST_READ_ORDER: assert property (@(posedge clk) disable iff (rst)
        buf_rd_en_o |-> buf_rd_slot_o == exp_slot && buf_rd_beat_o == exp_beat); // R6
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && $past(out_valid_o) && !retire_o |-> $stable(out_id_o)); // R7
    AST_ID_STEP: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && retire_o |->
            out_id_o == (($past(out_id_o) == ID_TOP) ? '0 : $past(out_id_o) + ID_W'(1))); // R7
    AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        retire_o |=> !retire_o); // R8
    AST_RETIRE_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        retire_o |-> $past(out_valid_o)); // R8

endmodule

bind chunk_stream_out chunk_stream_out_chk #(
    .SLOTS        (SLOTS),
    .PAUSE_STAGES (PAUSE_STAGES)
) u_chk (.*);

// File: tb/chunk_stream_out_test.sv
module chunk_stream_out_test;
    import chunk_stream_pkg::*;

    localparam int SLOTS = 32;
    localparam int ID_W  = $clog2(SLOTS);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  fill_done_i = 1'b0;
    logic                  pause_i = 1'b0;
    logic                  buf_rd_en_o;
    logic [ID_W-1:0]       buf_rd_slot_o;
    logic [BEAT_IDX_W-1:0] buf_rd_beat_o;
    logic [BEAT_W-1:0]     buf_rd_data_i = '0;
    logic                  out_valid_o;
    logic [BEAT_W-1:0]     out_data_o;
    logic [ID_W-1:0]       out_id_o;
    logic                  retire_o;

    always #5 clk = ~clk;

    chunk_stream_out #(.SLOTS(SLOTS), .PAUSE_STAGES(1)) uut (
        .clk           (clk),
        .rst           (rst),
        .fill_done_i   (fill_done_i),
        .pause_i       (pause_i),
        .buf_rd_en_o   (buf_rd_en_o),
        .buf_rd_slot_o (buf_rd_slot_o),
        .buf_rd_beat_o (buf_rd_beat_o),
        .buf_rd_data_i (buf_rd_data_i),
        .out_valid_o   (out_valid_o),
        .out_data_o    (out_data_o),
        .out_id_o      (out_id_o),
        .retire_o      (retire_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int fills    = 0;
    int retires  = 0;
    int exp_slot = 0;
    int exp_beat = 0;
    bit mon_en   = 0;
    bit retire_due = 0;
    bit wrapped  = 0;
    bit finished = 0;

    function automatic logic [BEAT_W-1:0] pat(input int s, input int b);
        logic [BEAT_W-1:0] r;
        for (int w = 0; w < BEAT_W / 32; w++) begin
            r[w*32 +: 32] = {8'(s), 8'(b), 8'(w), 8'h5A ^ 8'(s + b)};
        end
        return r;
    endfunction

    // Buffer model: data appears the cycle after a read request (R9).
    always @(posedge clk) begin
        buf_rd_data_i <= buf_rd_en_o ? pat(int'(buf_rd_slot_o), int'(buf_rd_beat_o))
                                     : {8{32'hDEADBEEF}};
    end

    task automatic check(input bit ok, input string req,
                         input logic [BEAT_W-1:0] act, input logic [BEAT_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard on every presented beat.
    always @(negedge clk) begin
        if (mon_en) begin
            if (retire_due) begin
                check(retire_o === 1'b1, "R8 retire pulse after beat 127", BEAT_W'(retire_o), 1);
            end else if (retire_o) begin
                check(1'b0, "R8 retire without preceding last beat", 1, 0);
            end
            if (retire_o) retires++;
            retire_due = 1'b0;
            if (out_valid_o) begin
                check(out_id_o == ID_W'(exp_slot), "R7 chunk id of beat",
                      BEAT_W'(out_id_o), BEAT_W'(exp_slot));
                check(out_data_o == pat(exp_slot, exp_beat), "R6 beat data and order",
                      out_data_o, pat(exp_slot, exp_beat));
                if (exp_beat == CHUNK_BEATS - 1) begin
                    exp_beat   = 0;
                    retire_due = 1'b1;
                    if (exp_slot == SLOTS - 1) begin
                        exp_slot = 0;
                        wrapped  = 1'b1;
                    end else begin
                        exp_slot++;
                    end
                end else begin
                    exp_beat++;
                end
            end
        end
    end

    task automatic fill_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fill_done_i = 1'b1;
            fills++;
        end
        @(negedge clk);
        fill_done_i = 1'b0;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while ((retires != fills || out_valid_o) && guard < 8000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        check(retires == fills, req, BEAT_W'(retires), BEAT_W'(fills));
    endtask

    task automatic measure_run(output int len);
        int guard = 0;
        len = 0;
        while (!out_valid_o && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        while (out_valid_o && len < 2000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        check(!out_valid_o && !retire_o && !buf_rd_en_o, "R1 outputs low in reset",
              BEAT_W'({out_valid_o, retire_o, buf_rd_en_o}), 0);
        check(out_id_o == '0, "R1 id zero in reset", BEAT_W'(out_id_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid_o && !retire_o && !buf_rd_en_o, "R1 outputs low after reset",
              BEAT_W'({out_valid_o, retire_o, buf_rd_en_o}), 0);
        mon_en = 1'b1;
    endtask

    task automatic test_eligibility;
        int busy = 0;
        int run;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (out_valid_o || buf_rd_en_o) busy++;
        end
        check(busy == 0, "R2 nothing read or shown before a fill", BEAT_W'(busy), 0);
        @(negedge clk);
        fill_done_i = 1'b1;
        fills++;
        @(negedge clk);
        fill_done_i = 1'b0;
        check(!out_valid_o, "R2 no beat one cycle after fill", BEAT_W'(out_valid_o), 0);
        check(buf_rd_en_o && buf_rd_slot_o == '0 && buf_rd_beat_o == '0,
              "R9 first request slot 0 beat 0",
              BEAT_W'({buf_rd_en_o, buf_rd_slot_o, buf_rd_beat_o}), BEAT_W'(1) << (ID_W + BEAT_IDX_W));
        @(negedge clk);
        check(!out_valid_o, "R2 no beat two cycles after fill", BEAT_W'(out_valid_o), 0);
        @(negedge clk);
        check(out_valid_o, "R2 first beat third cycle after fill", BEAT_W'(out_valid_o), 1);
        measure_run(run);
        check(run == CHUNK_BEATS, "R3 single chunk run length", BEAT_W'(run), CHUNK_BEATS);
        drain("R10 single chunk retired");
    endtask

    task automatic test_back_to_back;
        int run;
        fill_burst(3);
        measure_run(run);
        check(run == 3 * CHUNK_BEATS, "R3 gapless run over three chunks",
              BEAT_W'(run), 3 * CHUNK_BEATS);
        drain("R10 three chunks retired");
    endtask

    task automatic test_pause;
        int leak = 0;
        int guard = 0;
        fill_burst(2);
        while (!out_valid_o && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        repeat (10) @(negedge clk);
        pause_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int i = 3; i <= 30; i++) begin
            @(negedge clk);
            if (out_valid_o) leak++;
            if (i == 10) begin
                fill_done_i = 1'b1;
                fills++;
            end else begin
                fill_done_i = 1'b0;
            end
        end
        check(leak == 0, "R4 valid low from third cycle of pause", BEAT_W'(leak), 0);
        @(negedge clk);
        pause_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(out_valid_o, "R5 valid back in third cycle after release", BEAT_W'(out_valid_o), 1);
        for (int k = 0; k < 12; k++) begin
            repeat (7 + k) @(negedge clk);
            pause_i = 1'b1;
            @(negedge clk);
            pause_i = 1'b0;
        end
        drain("R10 chunks filled during pause all retired");
    endtask

    task automatic test_wrap;
        fill_burst(30);
        drain("R10 burst of thirty retired");
        check(wrapped, "R7 id wrapped past top slot", BEAT_W'(wrapped), 1);
        check(exp_slot == (fills % SLOTS), "R7 next id after wrap",
              BEAT_W'(exp_slot), BEAT_W'(fills % SLOTS));
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        test_reset;
        test_eligibility;
        test_back_to_back;
        test_pause;
        test_wrap;
        finished = 1'b1;
        report;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            report;
            $finish;
        end
    end

endmodule